// File: doc/BRIEF.md
# USB Function Interrupt Status Register

This block holds the interrupt status of a USB function controller as one 8-bit register. Three flags latch events until software clears them. The first flag is raised when an IN token arrives for the endpoint while its transmit FIFO has no valid data, so the host keeps getting NACK. The second flag is raised when the endpoint sends data and the host acknowledges it. The third flag is raised on every connect or disconnect, which the block detects from the bus-power sense pin.

Next to the flags, one read-only bit shows the synchronized bus-power level as it is now. A companion enable register sits on the same small CPU bus. A single level interrupt request is asserted while any flag is set together with its enable bit.

Software clears a flag by writing a byte that has a 0 in that flag's position and 1 everywhere else. A written 1 never sets a flag. If a hardware event and a clear hit the same flag in the same cycle, the event wins.

Top module: `usb_irq_flags`

## Requirements
- R1: While reset is low, and in the first cycle after it is released with the bus-power pin low, the status read (address 0) returns 0x00, the enable read (address 1) returns 0x00, and irq is 0.
- R2: Bits 7 to 4 of the status register always read 0, and writing 1s to them has no effect.
- R3: Status bit 3 reads the bus-power pin through a two-flop synchronizer (1 = connected), so a pin change appears after the second rising clock edge. No CPU write changes bit 3.
- R4: A one-cycle pulse on ep_in_nodata sets status bit 2 (transfer request), and the bit reads 1 after the next rising edge.
- R5: A one-cycle pulse on ep_tx_acked sets status bit 1 (transmit complete), and the bit reads 1 after the next rising edge.
- R6: Every rising or falling edge of the synchronized bus-power level sets status bit 0 (connection change), and the bit reads 1 after the third rising edge following the pin change.
- R7: A write to address 0 clears each of bits 2 to 0 whose written value is 0 and leaves each bit whose written value is 1 unchanged. A written 1 never sets a flag.
- R8: If a set event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R9: The enable register is at address 1. Its bits 2 to 0 are writable and read back, and its bits 7 to 3 read 0. Writes to any other address change nothing, and reads from other addresses return 0.
- R10: irq is 1 exactly when, for some n in 0 to 2, status bit n and enable bit n are both 1. Status bit 3 never drives irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ep_in_nodata | input | 1 | Pulse: IN token arrived with no valid transmit data |
| ep_tx_acked | input | 1 | Pulse: transmitted packet was acknowledged by the host |
| vbus_pin | input | 1 | Raw bus-power sense pin (asynchronous) |
| bus_addr | input | ADDR_W (2) | Register address: 0 = status, 1 = enable |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
A vector table applies single event pulses, all-ones writes, single-zero clearing writes, and clearing writes that arrive in the same cycle as the matching event. These patterns separate set logic, clear logic and set-over-clear priority. The enable register is stepped through masks that select one flag at a time, which shows that irq follows only the enabled flag and ignores the others. Directed tests walk the bus-power pin up and down and read the register each cycle. This confirms the two-cycle level latency, the three-cycle flag latency on both edges, and that writes can neither clear the live bit nor touch the reserved bits.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
    localparam int REG_W       = 8;
    localparam int NUM_FLAGS   = 3;
    localparam int BIT_CONN    = 0;
    localparam int BIT_XDONE   = 1;
    localparam int BIT_XREQ    = 2;
    localparam int BIT_VBUS    = 3;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/usbirq_vbus_sense.sv
module usbirq_vbus_sense #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic change
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sense_t;

    sense_t sense_d, sense_q;

    always_comb begin
        sense_d      = sense_q;
        sense_d.sync = {sense_q.sync[STAGES-2:0], pin};
        sense_d.prev = sense_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sense_q <= '0;
        else        sense_q <= sense_d;
    end

    assign level  = sense_q.sync[STAGES-1];
    assign change = sense_q.sync[STAGES-1] ^ sense_q.prev;
endmodule

// File: rtl/usbirq_flag_bank.sv
module usbirq_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic         clr_we,
    input  logic [N-1:0] clr_data,
    input  logic         en_we,
    input  logic [N-1:0] en_data,
    output logic [N-1:0] flags,
    output logic [N-1:0] enables
);
    typedef struct packed {
        logic [N-1:0] flags;
        logic [N-1:0] en;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < N; i++) begin
            // a hardware event takes priority over a clearing write
            bank_d.flags[i] = set_evt[i] |
                              (bank_q.flags[i] & ~(clr_we & ~clr_data[i]));
        end
        if (en_we) bank_d.en = en_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign flags   = bank_q.flags;
    assign enables = bank_q.en;
endmodule

// File: rtl/usbirq_irq_merge.sv
module usbirq_irq_merge #(
    parameter int N = 3
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic         irq
);
    logic [N-1:0] terms;

    for (genvar g = 0; g < N; g++) begin : g_term
        assign terms[g] = flags[g] & enables[g];
    end

    assign irq = |terms;
endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags
    import usbirq_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int FLAG_ADDR = 0,
    parameter int EN_ADDR   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ep_in_nodata,
    input  logic              ep_tx_acked,
    input  logic              vbus_pin,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);
    logic                 vbus_level;
    logic                 vbus_change;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flag_vec;
    logic [NUM_FLAGS-1:0] en_vec;
    logic                 sel_flag;
    logic                 sel_en;
    logic                 unused_wdata;

    assign sel_flag     = (bus_addr == ADDR_W'(FLAG_ADDR));
    assign sel_en       = (bus_addr == ADDR_W'(EN_ADDR));
    assign unused_wdata = ^bus_wdata[REG_W-1:NUM_FLAGS];

    usbirq_vbus_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (vbus_pin),
        .level  (vbus_level),
        .change (vbus_change)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[BIT_XREQ]  = ep_in_nodata;
        set_vec[BIT_XDONE] = ep_tx_acked;
        set_vec[BIT_CONN]  = vbus_change;
    end

    usbirq_flag_bank #(.N(NUM_FLAGS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (set_vec),
        .clr_we   (bus_we & sel_flag),
        .clr_data (bus_wdata[NUM_FLAGS-1:0]),
        .en_we    (bus_we & sel_en),
        .en_data  (bus_wdata[NUM_FLAGS-1:0]),
        .flags    (flag_vec),
        .enables  (en_vec)
    );

    usbirq_irq_merge #(.N(NUM_FLAGS)) u_merge (
        .flags   (flag_vec),
        .enables (en_vec),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_flag) begin
            bus_rdata[NUM_FLAGS-1:0] = flag_vec;
            bus_rdata[BIT_VBUS]      = vbus_level;
        end else if (sel_en) begin
            bus_rdata[NUM_FLAGS-1:0] = en_vec;
        end
    end
endmodule

// File: rtl/usbirq_checker.sv
module usbirq_checker #(
    parameter int ADDR_W    = 2,
    parameter int FLAG_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ep_in_nodata,
    input logic              ep_tx_acked,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              irq,
    input logic [2:0]        flag_vec,
    input logic [2:0]        en_vec
);
    logic wr_flag;
    assign wr_flag = bus_we && (bus_addr == ADDR_W'(FLAG_ADDR));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(FLAG_ADDR)) |-> (bus_rdata[7:4] == 4'h0));

    assert_xreq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ep_in_nodata |=> flag_vec[2]);

    assert_xdone_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ep_tx_acked |=> flag_vec[1]);

    assert_xdone_only_by_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_vec[1]) |-> $past(ep_tx_acked));

    assert_clear_by_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && !bus_wdata[2] && !ep_in_nodata) |=> !flag_vec[2]);

    assert_one_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && bus_wdata[1] && !ep_tx_acked) |=> (flag_vec[1] == $past(flag_vec[1])));

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && !bus_wdata[2] && ep_in_nodata) |=> flag_vec[2]);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_vec == 3'b000 || en_vec == 3'b000) |-> !irq);
endmodule

bind usb_irq_flags usbirq_checker #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ep_in_nodata (ep_in_nodata),
    .ep_tx_acked  (ep_tx_acked),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq          (irq),
    .flag_vec     (flag_vec),
    .en_vec       (en_vec)
);

// File: tb/tb_usb_irq_flags.sv
module tb_usb_irq_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ep_in_nodata = 1'b0;
    logic       ep_tx_acked = 1'b0;
    logic       vbus_pin = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    usb_irq_flags dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ep_in_nodata (ep_in_nodata),
        .ep_tx_acked  (ep_tx_acked),
        .vbus_pin     (vbus_pin),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq          (irq)
    );

    typedef struct packed {
        logic       nack;
        logic       ack;
        logic       we;
        logic [1:0] addr;
        logic [7:0] wdata;
        logic [7:0] exp_flag;
        logic       exp_irq;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'h04, 1'b0},  // R4 IN without data
        '{1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 8'h06, 1'b0},  // R5 tx acked
        '{1'b0, 1'b0, 1'b1, 2'd0, 8'hFF, 8'h06, 1'b0},  // R7 all ones keeps
        '{1'b0, 1'b0, 1'b1, 2'd0, 8'hFB, 8'h02, 1'b0},  // R7 clear bit 2
        '{1'b0, 1'b0, 1'b1, 2'd1, 8'h02, 8'h02, 1'b1},  // R10 enable bit 1
        '{1'b0, 1'b0, 1'b1, 2'd1, 8'h04, 8'h02, 1'b0},  // R10 enable bit 2 only
        '{1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'h06, 1'b1},  // R4 set again
        '{1'b1, 1'b0, 1'b1, 2'd0, 8'hFB, 8'h06, 1'b1},  // R8 set beats clear
        '{1'b0, 1'b0, 1'b1, 2'd0, 8'hF9, 8'h00, 1'b0},  // R7 clear two flags
        '{1'b0, 1'b1, 1'b1, 2'd0, 8'h00, 8'h02, 1'b0},  // R8 ack beats clear-all
        '{1'b0, 1'b0, 1'b1, 2'd0, 8'hFF, 8'h02, 1'b0},  // R7 a 1 never sets
        '{1'b0, 1'b0, 1'b1, 2'd2, 8'h00, 8'h02, 1'b0},  // R9 other address ignored
        '{1'b0, 1'b0, 1'b1, 2'd1, 8'hFF, 8'h02, 1'b1},  // R10 all enabled
        '{1'b0, 1'b0, 1'b1, 2'd0, 8'hFD, 8'h00, 1'b0}   // R7 clear bit 1
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic read_chk(input logic [1:0] a, input string req, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check8(req, bus_rdata, exp);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        bus_wdata = 8'h00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        read_chk(2'd0, "R1 status in reset", 8'h00);
        read_chk(2'd1, "R1 enable in reset", 8'h00);
        check8("R1 irq in reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        read_chk(2'd0, "R1 status after release", 8'h00);
        check8("R1 irq after release", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            ep_in_nodata = VECS[i].nack;
            ep_tx_acked  = VECS[i].ack;
            bus_we       = VECS[i].we;
            bus_addr     = VECS[i].addr;
            bus_wdata    = VECS[i].wdata;
            @(posedge clk);
            @(negedge clk);
            ep_in_nodata = 1'b0;
            ep_tx_acked  = 1'b0;
            bus_we       = 1'b0;
            bus_wdata    = 8'h00;
            read_chk(2'd0, $sformatf("R4/R5/R7/R8/R9 vector %0d status", i), VECS[i].exp_flag);
            check8($sformatf("R10 vector %0d irq", i), {7'd0, irq}, {7'd0, VECS[i].exp_irq});
        end

        // R9 enable readback: bits 2..0 hold 1 after 0xFF, upper bits read 0
        read_chk(2'd1, "R9 enable readback", 8'h07);
        read_chk(2'd3, "R9 unmapped read", 8'h00);

        // R3 / R6: connect
        bus_addr = 2'd0;
        vbus_pin = 1'b1;
        @(posedge clk); @(negedge clk);
        read_chk(2'd0, "R3 one edge after connect", 8'h00);
        @(posedge clk); @(negedge clk);
        read_chk(2'd0, "R3 level after two edges", 8'h08);
        check8("R10 live bit gives no irq", {7'd0, irq}, 8'h00);
        @(posedge clk); @(negedge clk);
        read_chk(2'd0, "R6 connect flag after three edges", 8'h09);
        check8("R10 irq from connection flag", {7'd0, irq}, 8'h01);

        write_reg(2'd0, 8'hF7);
        read_chk(2'd0, "R3 write cannot clear live bit", 8'h09);
        write_reg(2'd0, 8'hFE);
        read_chk(2'd0, "R7 clear connection flag", 8'h08);
        check8("R10 irq drops after clear", {7'd0, irq}, 8'h00);

        // R6: disconnect
        vbus_pin = 1'b0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        read_chk(2'd0, "R3 level low after two edges", 8'h00);
        @(posedge clk); @(negedge clk);
        read_chk(2'd0, "R6 disconnect flag", 8'h01);

        // R2: reserved bits ignore writes of 1
        write_reg(2'd0, 8'hF0);
        read_chk(2'd0, "R2 reserved bits read 0", 8'h00);
        write_reg(2'd1, 8'hF8);
        read_chk(2'd1, "R9 enable upper bits read 0", 8'h00);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule